// File: doc/BRIEF.md
# Microcontroller Clock Source Controller

This unit decides where a small microcontroller's core clock comes from and keeps the analog clock parts under control. A 3-bit oscillator configuration is captured once, on the first clock edge after reset release. It fixes three things: which primary source family is used (an external clock, a crystal, or the on-chip oscillator), whether the 4 MHz to 96 MHz frequency multiplier may ever run, and whether the clock-out pin is driven.

The multiplier is turned on by a software enable bit. The core keeps running from the bypass clock until a programmable lock wait has elapsed and the multiplier reports lock. A selectable input prescaler sits ahead of the multiplier. Software may move the core to a secondary timer clock or to the postscaled internal clock; doing so turns the primary oscillator off unless the reference clock output still needs it. Two-speed start-up holds the core on the internal oscillator until the off-chip source has produced enough edges. A fail-safe monitor runs in the reference domain, flags a stopped main clock and moves the core to the internal oscillator.

The analog oscillator, the multiplier and glitch-free clock multiplexers are outside this block. They are driven through the registered enable and select outputs listed below. The block clock `clk` is the internal reference and peripheral clock.

Top module: `clkctl_top`

## Requirements
- R1: The mode field is captured at the first rising edge after reset release. Bits [2:1] select the source family: 00 is external clock, 01 is crystal, 10 and 11 are internal oscillator. The `primSrc` output encodes these as 0 for external, 1 for crystal and 2 for internal.
- R2: `pllEn` is high only when mode bit 0 is 1, `pllSwEn` is 1, the primary source is needed and the part is awake. When mode bit 0 is 0, `pllEn` stays 0 whatever `pllSwEn` holds.
- R3: `preSel` values 0 to 7 select divide ratios 12, 10, 6, 5, 4, 3, 2 and 1. `preRatio` reports the ratio selected at the previous edge. `preTick` pulses once every ratio cycles.
- R4: After the multiplier is enabled, `coreSel` stays at bypass (1) until LOCK_CYCLES cycles have passed with `lockDone` high, and only then moves to multiplied (2). It never reaches 2 while `lockDone` is low. Clearing `pllSwEn` returns it to bypass within two cycles.
- R5: In modes with mode bit 1 equal to 0, `clkOut` is `clk` divided by four. In the other modes it stays low.
- R6: Sleep stops `clkOut` low and drops `primOscEn` and `pllEn` one cycle later. Idle leaves `clkOut` running. `coreRun` is high only when neither sleep nor idle is asserted.
- R7: `clkSwSel` = 01 puts the core on the secondary timer clock (`coreSel` 3), and 10 or 11 puts it on the postscaled internal clock (4). `primOscEn` is high only when `clkSwSel` = 00 or `refOutNeed` is 1.
- R8: With two-speed start-up configured in external or crystal modes, `coreSel` is 0 (internal oscillator) until READY_EDGES main-clock rising edges have been seen since the oscillator was enabled. This count restarts after every sleep. Without two-speed start-up the core goes straight to bypass.
- R9: With fail-safe configured in external or crystal modes, FAIL_LIMIT consecutive reference cycles without a synchronized main-clock rising edge set `failFlag`. The core then moves to `coreSel` 0 while the primary source is selected.
- R10: `failFlag` stays set when the main clock returns and is cleared only by reset. It never sets when fail-safe is not configured.
- R11: While reset is asserted, every output is 0, which includes `coreSel` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference and peripheral clock |
| rstN | input | 1 | Active-low reset |
| modeIn | input | 3 | Oscillator mode configuration |
| twoSpeedCfg | input | 1 | Two-speed start-up configuration |
| failSafeCfg | input | 1 | Fail-safe monitor configuration |
| preSel | input | 3 | Multiplier input prescaler select |
| pllSwEn | input | 1 | Software multiplier enable |
| lockDone | input | 1 | Multiplier lock indicator |
| clkSwSel | input | 2 | Software core clock choice |
| refOutNeed | input | 1 | Reference clock output needs primary source |
| sleep | input | 1 | Sleep power state |
| idle | input | 1 | Idle power state |
| mainClkIn | input | 1 | Main clock, asynchronous to clk |
| primOscEn | output | 1 | Primary oscillator enable |
| primSrc | output | 2 | Primary source family |
| pllEn | output | 1 | Multiplier enable |
| coreSel | output | 3 | Core clock mux select |
| coreRun | output | 1 | Core clock enable |
| clkOut | output | 1 | Divided clock pin output |
| preRatio | output | 4 | Active prescaler divide ratio |
| preTick | output | 1 | Prescaler divide strobe |
| failFlag | output | 1 | Sticky main-clock failure flag |

## Verification
Every select and enable output is registered. A change to `sleep`, `idle`, `clkSwSel`, `refOutNeed` or `pllSwEn` shows up one edge later. The bench drives inputs at the falling edge and samples at least two falling edges afterwards. The multiplied path needs the lock count plus two registers: each sample inside the first LOCK_CYCLES cycles must still read bypass, and the multiplied select is checked four cycles after that window. Results that depend on the asynchronous main clock pass through the two-flop synchronizer first. For those, two-speed and fail-safe checks use margins of several main periods: half the limit for "not yet" and the limit plus ten cycles for "already".

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef enum logic [2:0] {
    CORE_INTOSC     = 3'd0,
    CORE_BYPASS     = 3'd1,
    CORE_MULT       = 3'd2,
    CORE_SECONDARY  = 3'd3,
    CORE_POSTSCALED = 3'd4
  } coreSel_e;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_INT  = 2'd2
  } primSrc_e;

  // Next-state strobes from control to datapath
  typedef struct packed {
    logic     oscOn;
    logic     pllOn;
    coreSel_e core;
    logic     pinRun;
    logic     coreRun;
    primSrc_e src;
  } ctlStrobe_t;

  function automatic logic [3:0] preRatioOf(input logic [2:0] sel);
    logic [3:0] r;
    case (sel)
      3'd0:    r = 4'd12;
      3'd1:    r = 4'd10;
      3'd2:    r = 4'd6;
      3'd3:    r = 4'd5;
      3'd4:    r = 4'd4;
      3'd5:    r = 4'd3;
      3'd6:    r = 4'd2;
      default: r = 4'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
#(
  parameter int LOCK_CYCLES = 100,
  parameter int READY_EDGES = 1024,
  parameter int FAIL_LIMIT  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeIn,
  input  logic       twoSpeedCfg,
  input  logic       failSafeCfg,
  input  logic       pllSwEn,
  input  logic       lockDone,
  input  logic [1:0] clkSwSel,
  input  logic       refOutNeed,
  input  logic       sleep,
  input  logic       idle,
  input  logic       mainClkIn,
  output ctlStrobe_t strobe,
  output logic       cfgValid,
  output logic [2:0] cfgMode,
  output logic       failFlag
);

  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam int RW = $clog2(READY_EDGES + 1);
  localparam int FW = $clog2(FAIL_LIMIT + 1);
  localparam logic [LW-1:0] LOCK_END  = LW'(LOCK_CYCLES);
  localparam logic [RW-1:0] READY_END = RW'(READY_EDGES);
  localparam logic [FW-1:0] FAIL_END  = FW'(FAIL_LIMIT);

  logic cfgTwoSpeed, cfgFailSafe;

  // Configuration captured once after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgValid    <= 1'b0;
      cfgMode     <= '0;
      cfgTwoSpeed <= 1'b0;
      cfgFailSafe <= 1'b0;
    end else if (!cfgValid) begin
      cfgValid    <= 1'b1;
      cfgMode     <= modeIn;
      cfgTwoSpeed <= twoSpeedCfg;
      cfgFailSafe <= failSafeCfg;
    end
  end

  // Main clock synchronizer into reference domain
  logic [SYNC_STAGES:0] mainSync;
  logic mainRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mainSync <= '0;
    else       mainSync <= {mainSync[SYNC_STAGES-1:0], mainClkIn};
  end

  assign mainRise = mainSync[SYNC_STAGES-1] & ~mainSync[SYNC_STAGES];

  // Mode decode
  logic offChip, multCapable, pinMode, swPrimary;
  logic primNeeded, pllWant, monActive, primReady;

  always_comb begin
    offChip     = ~cfgMode[2];
    multCapable = cfgMode[0];
    pinMode     = ~cfgMode[1];
    swPrimary   = (clkSwSel == 2'b00);
    primNeeded  = cfgValid & ~sleep & (swPrimary | refOutNeed);
    pllWant     = primNeeded & multCapable & pllSwEn;
    monActive   = primNeeded & offChip & cfgFailSafe;
  end

  // Two-speed readiness: main-clock edges since enable
  logic [RW-1:0] readyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   readyCnt <= '0;
    else if (!primNeeded)                        readyCnt <= '0;
    else if (mainRise && readyCnt != READY_END)  readyCnt <= readyCnt + 1'b1;
  end

  assign primReady = offChip ? (readyCnt == READY_END) : primNeeded;

  // Fail-safe silence counter and sticky flag
  logic [FW-1:0] silentCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      silentCnt <= '0;
      failFlag  <= 1'b0;
    end else begin
      if (!monActive || mainRise)   silentCnt <= '0;
      else if (silentCnt != FAIL_END) silentCnt <= silentCnt + 1'b1;
      if (monActive && silentCnt == FAIL_END) failFlag <= 1'b1;
    end
  end

  // Lock wait and registered switch-over handshake
  logic [LW-1:0] lockCnt;
  logic          multRdy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt <= '0;
      multRdy <= 1'b0;
    end else if (!pllWant) begin
      lockCnt <= '0;
      multRdy <= 1'b0;
    end else begin
      if (lockCnt != LOCK_END) lockCnt <= lockCnt + 1'b1;
      multRdy <= (lockCnt == LOCK_END) & lockDone;
    end
  end

  // Core source choice
  coreSel_e coreNext;

  always_comb begin
    if (!cfgValid)                      coreNext = CORE_INTOSC;
    else if (clkSwSel == 2'b01)         coreNext = CORE_SECONDARY;
    else if (clkSwSel[1])               coreNext = CORE_POSTSCALED;
    else if (failFlag)                  coreNext = CORE_INTOSC;
    else if (cfgTwoSpeed && !primReady) coreNext = CORE_INTOSC;
    else if (pllWant && multRdy)        coreNext = CORE_MULT;
    else                                coreNext = CORE_BYPASS;
  end

  always_comb begin
    strobe.oscOn   = primNeeded;
    strobe.pllOn   = pllWant;
    strobe.core    = coreNext;
    strobe.pinRun  = cfgValid & pinMode & ~sleep;
    strobe.coreRun = cfgValid & ~sleep & ~idle;
    if (!cfgValid)        strobe.src = SRC_EXT;
    else if (cfgMode[2])  strobe.src = SRC_INT;
    else if (cfgMode[1])  strobe.src = SRC_XTAL;
    else                  strobe.src = SRC_EXT;
  end

endmodule

// File: rtl/clkctl_dp.sv
module clkctl_dp
  import clkctl_pkg::*;
#(
  parameter int PIN_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic [2:0] preSel,
  output logic       primOscEn,
  output logic [1:0] primSrc,
  output logic       pllEn,
  output logic [2:0] coreSel,
  output logic       coreRun,
  output logic       clkOut,
  output logic [3:0] preRatio,
  output logic       preTick
);

  localparam int DW = $clog2(PIN_DIV);

  ctlStrobe_t stQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= '0;
    else       stQ <= strobe;
  end

  assign primOscEn = stQ.oscOn;
  assign pllEn     = stQ.pllOn;
  assign coreSel   = stQ.core;
  assign coreRun   = stQ.coreRun;
  assign primSrc   = stQ.src;

  // Pin divider, held cleared while stopped
  logic [DW-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              divCnt <= '0;
    else if (!strobe.pinRun) divCnt <= '0;
    else                    divCnt <= divCnt + 1'b1;
  end

  assign clkOut = divCnt[DW-1];

  // Prescaler ratio and divide strobe
  logic [3:0] ratioNow, preCnt;

  assign ratioNow = preRatioOf(preSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      preTick  <= 1'b0;
      preRatio <= '0;
    end else begin
      preRatio <= ratioNow;
      if (preCnt >= ratioNow - 4'd1) begin
        preCnt  <= '0;
        preTick <= 1'b1;
      end else begin
        preCnt  <= preCnt + 1'b1;
        preTick <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int LOCK_CYCLES = 100,
  parameter int READY_EDGES = 1024,
  parameter int FAIL_LIMIT  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeIn,
  input  logic       twoSpeedCfg,
  input  logic       failSafeCfg,
  input  logic [2:0] preSel,
  input  logic       pllSwEn,
  input  logic       lockDone,
  input  logic [1:0] clkSwSel,
  input  logic       refOutNeed,
  input  logic       sleep,
  input  logic       idle,
  input  logic       mainClkIn,
  output logic       primOscEn,
  output logic [1:0] primSrc,
  output logic       pllEn,
  output logic [2:0] coreSel,
  output logic       coreRun,
  output logic       clkOut,
  output logic [3:0] preRatio,
  output logic       preTick,
  output logic       failFlag
);

  ctlStrobe_t strobe;
  logic       cfgValid;
  logic [2:0] cfgMode;

  clkctl_ctrl #(
    .LOCK_CYCLES(LOCK_CYCLES),
    .READY_EDGES(READY_EDGES),
    .FAIL_LIMIT (FAIL_LIMIT),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .twoSpeedCfg(twoSpeedCfg),
    .failSafeCfg(failSafeCfg), .pllSwEn(pllSwEn), .lockDone(lockDone),
    .clkSwSel(clkSwSel), .refOutNeed(refOutNeed), .sleep(sleep), .idle(idle),
    .mainClkIn(mainClkIn), .strobe(strobe), .cfgValid(cfgValid),
    .cfgMode(cfgMode), .failFlag(failFlag)
  );

  clkctl_dp #(.PIN_DIV(4)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preSel(preSel),
    .primOscEn(primOscEn), .primSrc(primSrc), .pllEn(pllEn),
    .coreSel(coreSel), .coreRun(coreRun), .clkOut(clkOut),
    .preRatio(preRatio), .preTick(preTick)
  );

endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgValid,
  input logic [2:0] cfgMode,
  input logic [1:0] clkSwSel,
  input logic       sleep,
  input logic       pllEn,
  input logic       primOscEn,
  input logic [2:0] coreSel,
  input logic       clkOut,
  input logic       failFlag
);

  // R2
  pll_mode_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !cfgMode[0]) |-> !pllEn);

  // R4
  mult_needs_pll_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreSel == 3'd2) |-> $past(pllEn));

  // R6
  sleep_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(sleep) |-> (!primOscEn && !pllEn && !clkOut));

  // R7
  secondary_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && clkSwSel == 2'b01) |=> (coreSel == 3'd3));

  // R10
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(failFlag) |-> failFlag);

endmodule

bind clkctl_top clkctl_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgMode(cfgMode),
  .clkSwSel(clkSwSel), .sleep(sleep), .pllEn(pllEn), .primOscEn(primOscEn),
  .coreSel(coreSel), .clkOut(clkOut), .failFlag(failFlag)
);

// File: tb/clkctl_top_tb.sv
module clkctl_top_tb;

  localparam int LK = 20;
  localparam int RE = 32;
  localparam int FL = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeIn = '0;
  logic       twoSpeedCfg = 1'b0, failSafeCfg = 1'b0;
  logic [2:0] preSel = '0;
  logic       pllSwEn = 1'b0, lockDone = 1'b0;
  logic [1:0] clkSwSel = '0;
  logic       refOutNeed = 1'b0, sleep = 1'b0, idle = 1'b0;
  logic       mainClk = 1'b0, mainRun = 1'b0;
  logic       primOscEn, pllEn, coreRun, clkOut, preTick, failFlag;
  logic [1:0] primSrc;
  logic [2:0] coreSel;
  logic [3:0] preRatio;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  initial begin
    #5;
    forever begin
      #30;
      if (mainRun) mainClk = ~mainClk;
    end
  end

  clkctl_top #(.LOCK_CYCLES(LK), .READY_EDGES(RE), .FAIL_LIMIT(FL)) u_dut (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .twoSpeedCfg(twoSpeedCfg),
    .failSafeCfg(failSafeCfg), .preSel(preSel), .pllSwEn(pllSwEn),
    .lockDone(lockDone), .clkSwSel(clkSwSel), .refOutNeed(refOutNeed),
    .sleep(sleep), .idle(idle), .mainClkIn(mainClk), .primOscEn(primOscEn),
    .primSrc(primSrc), .pllEn(pllEn), .coreSel(coreSel), .coreRun(coreRun),
    .clkOut(clkOut), .preRatio(preRatio), .preTick(preTick), .failFlag(failFlag)
  );

  function automatic int expRatio(input logic [2:0] s);
    case (s)
      3'd0: return 12; 3'd1: return 10; 3'd2: return 6; 3'd3: return 5;
      3'd4: return 4;  3'd5: return 3;  3'd6: return 2; default: return 1;
    endcase
  endfunction

  function automatic int expSrc(input logic [2:0] m);
    return m[2] ? 2 : (m[1] ? 1 : 0);
  endfunction

  function automatic int expPinRises(input logic [2:0] m, input int n);
    return m[1] ? 0 : n / 4;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic countRises(input int n, output int rises);
    logic prev;
    rises = 0;
    prev = clkOut;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (clkOut && !prev) rises++;
      prev = clkOut;
    end
  endtask

  task automatic countTicks(input int n, output int ticks);
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (preTick) ticks++;
    end
  endtask

  task automatic doReset(input logic [2:0] m, input logic ts, input logic fs);
    rstN = 1'b0; modeIn = m; twoSpeedCfg = ts; failSafeCfg = fs;
    tick(3);
    rstN = 1'b1;
    tick(2);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int r;
    int bad;
    void'($urandom(32'h5eed_c10c));

    // R11: reset values
    rstN = 1'b0; pllSwEn = 1'b1; modeIn = 3'b101;
    tick(3);
    check("R11 outputs in reset",
          {primOscEn, pllEn, coreRun, clkOut, preTick, failFlag, primSrc, coreSel, preRatio}, 0);

    // R1 R2 R5: every mode with random software enable
    for (int m = 0; m < 8; m++) begin
      logic sw;
      sw = 1'($urandom % 2);
      pllSwEn = sw; lockDone = 1'b0; clkSwSel = 2'b00;
      doReset(3'(m), 1'b0, 1'b0);
      tick(2);
      check("R1 primSrc", primSrc, expSrc(3'(m)));
      check("R1 primOscEn", primOscEn, 1);
      check("R2 pllEn", pllEn, int'(m[0] & sw));
      countRises(16, r);
      check("R5 clkOut rises", r, expPinRises(3'(m), 16));
    end

    // R1: mode input changes after capture are ignored
    modeIn = 3'b110; tick(3);
    check("R1 mode frozen after release", primSrc, expSrc(3'b111));

    // R2: non-multiplier internal mode with enable set
    pllSwEn = 1'b1;
    doReset(3'b100, 1'b0, 1'b0);
    tick(2);
    check("R2 pll forced off", pllEn, 0);
    check("R2 core stays bypass", coreSel, 1);

    // R3: prescaler table, directed then random
    for (int k = 0; k < 12; k++) begin
      logic [2:0] s;
      s = (k < 8) ? 3'(k) : 3'($urandom % 8);
      preSel = s;
      tick(16);
      check("R3 preRatio", preRatio, expRatio(s));
      countTicks(60, r);
      check("R3 preTick count", r, 60 / expRatio(s));
    end

    // R7: software clock choice
    clkSwSel = 2'b01; tick(2);
    check("R7 secondary select", coreSel, 3);
    check("R7 primary off", primOscEn, 0);
    refOutNeed = 1'b1; tick(2);
    check("R7 reference keeps primary", primOscEn, 1);
    clkSwSel = 2'b10; tick(2);
    check("R7 postscaled select", coreSel, 4);
    clkSwSel = 2'b00; refOutNeed = 1'b0; tick(2);
    check("R7 back to primary", coreSel, 1);

    // R6: idle and sleep
    idle = 1'b1; tick(2);
    check("R6 idle stops core", coreRun, 0);
    countRises(16, r);
    check("R6 idle keeps clkOut", r, 4);
    idle = 1'b0; sleep = 1'b1; tick(1);
    countRises(16, r);
    check("R6 sleep stops clkOut", r, 0);
    check("R6 sleep clkOut low", clkOut, 0);
    check("R6 sleep osc off", primOscEn, 0);
    check("R6 sleep core off", coreRun, 0);
    sleep = 1'b0; tick(2);
    check("R6 wake core on", coreRun, 1);

    // R4: lock wait with lock indicator high
    pllSwEn = 1'b0; lockDone = 1'b1;
    doReset(3'b101, 1'b0, 1'b0);
    pllSwEn = 1'b1;
    bad = 0;
    for (int i = 0; i < LK; i++) begin
      tick(1);
      if (coreSel == 3'd2) bad++;
    end
    check("R4 bypass during lock wait", bad, 0);
    tick(4);
    check("R4 multiplied after lock", coreSel, 2);
    pllSwEn = 1'b0; tick(2);
    check("R4 disable returns to bypass", coreSel, 1);
    check("R2 pll off after disable", pllEn, 0);

    // R4: no switch without lock indicator
    lockDone = 1'b0; pllSwEn = 1'b1;
    tick(LK + 20);
    check("R4 no lock indicator stays bypass", coreSel, 1);
    check("R2 pll on while waiting", pllEn, 1);
    pllSwEn = 1'b0; lockDone = 1'b0;

    // R8: two-speed start-up with crystal
    mainRun = 1'b1;
    doReset(3'b010, 1'b1, 1'b0);
    tick(3);
    check("R8 internal osc at start", coreSel, 0);
    tick(RE * 3 + 40);
    check("R8 primary after ready", coreSel, 1);
    sleep = 1'b1; tick(2);
    check("R6 sleep osc off crystal", primOscEn, 0);
    sleep = 1'b0; tick(3);
    check("R8 internal osc after wake", coreSel, 0);
    tick(RE * 3 + 40);
    check("R8 primary after wake ready", coreSel, 1);
    mainRun = 1'b0;
    doReset(3'b010, 1'b0, 1'b0);
    check("R8 no two-speed goes bypass", coreSel, 1);

    // R9 R10: fail-safe
    mainRun = 1'b1;
    doReset(3'b000, 1'b0, 1'b1);
    tick(100);
    check("R9 no fail with running clock", failFlag, 0);
    check("R9 bypass while healthy", coreSel, 1);
    mainRun = 1'b0;
    tick(FL / 2);
    check("R9 no fail before limit", failFlag, 0);
    tick(FL + 10);
    check("R9 fail after limit", failFlag, 1);
    check("R9 core to internal osc", coreSel, 0);
    mainRun = 1'b1;
    tick(60);
    check("R10 fail sticky", failFlag, 1);
    check("R10 core stays internal", coreSel, 0);
    doReset(3'b000, 1'b0, 1'b1);
    check("R10 reset clears fail", failFlag, 0);
    mainRun = 1'b0;
    doReset(3'b000, 1'b0, 1'b0);
    tick(FL * 3);
    check("R10 monitor off never fails", failFlag, 0);
    check("R10 core stays bypass", coreSel, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule